// File: doc/BRIEF.md
# Double-Buffered Fault Status Register

This block holds a bank of fault flags for a serial-interface slave in two layers. An inner sticky latch per fault catches a condition on the first clock it is seen. The latch lets go only when two things are both true: the condition has gone away, and the fault has actually reached the host in a completed response. An outer snapshot layer copies the whole inner layer once per frame, when chip select is released. That snapshot is the word the response shift register loads for the following frame.

Chip select arrives asynchronously. It passes through a synchroniser, and a release edge is detected on the synchronised value. The snapshot is taken on the clock edge after that detection. The surrounding shift logic supplies the other three controls. It says when it has copied the snapshot into its shift register. It says when a frame that carried that word has completed validly. It also says, at frame end, whether the command just received was the general-configuration command. After that command, one chosen fault bit of the snapshot is refreshed from its live condition a fixed number of cycles later. The serial shifting itself lies outside this block.

Top module: `fault_dbuf_reg`

## Requirements
- R1: A synchronous active-high reset clears every inner latch and every snapshot bit to 0. The first frame end after reset then presents an all-zero word, even if faults were latched before the reset.
- R2: A fault input that is high for a single clock sets its inner latch. At the next frame end that bit appears as 1 in `snap_o`, even though the condition has already gone. Bit i of `snap_o` belongs to `fault_in[i]`.
- R3: `snap_o` changes only at a frame end or at a configuration refresh. A frame end is taken on the third rising clock edge after `cs_n` goes from low to high: two synchroniser stages plus one load edge. Fault activity between frame ends leaves `snap_o` unchanged.
- R4: An inner latch is cleared only once its condition is low and it has been reported. If the fault is reported while the condition is still high, the bit stays latched, and it clears once the condition drops without a second report.
- R5: A bit counts as reported only when two things happen in order. First, `rsp_load` copies a snapshot holding that bit as 1. Then a `tx_done` pulse follows. A `tx_done` with no such prior load leaves the bit latched.
- R6: If a fault input is high in the same cycle that its latch would otherwise clear, the latch stays set.
- R7: A frame end with `cfg_cmd` high arms a refresh. RS_DLY clock edges after that snapshot load (default 8), snapshot bit CFG_BIT (default 2) takes the live value of `fault_in[CFG_BIT]`. The other snapshot bits are unchanged. With `cfg_cmd` low at frame end, no refresh happens.
- R8: A frame end that comes while a refresh is still pending, with `cfg_cmd` low, cancels that refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| fault_in | input | NF | Raw fault conditions, one per bit, synchronous to clk |
| cfg_cmd | input | 1 | High at frame end when the received command was the general-configuration command |
| rsp_load | input | 1 | One-cycle strobe: the response shift register copied `snap_o` |
| tx_done | input | 1 | One-cycle strobe: the frame carrying the last loaded word completed validly |
| snap_o | output | NF | Snapshot word presented for the next response |

## Verification
The two functions that can fall in the same cycle are the setting of a latch by a fresh fault and its clearing after a report. To provoke this, a fault is latched, snapshotted and loaded, and it then drops. Next, a `tx_done` pulse and a one-cycle re-assertion of that fault are driven on the same clock edge. The chip-select release is timed so that the following snapshot samples the latch on the edge just after that collision. The bench judges the outcome from `snap_o`: the bit must still read 1, because the set wins.

// File: rtl/fdb_pkg.sv
`timescale 1ns/1ps
package fdb_pkg;

    // State kept by one fault cell.
    typedef struct packed {
        logic latched;   // inner sticky fault latch
        logic reported;  // latched value has reached the host
    } cell_st_t;

    // What the snapshot register does in a given cycle.
    typedef enum logic [1:0] {
        SNAP_KEEP    = 2'd0,
        SNAP_COPY    = 2'd1,
        SNAP_REFRESH = 2'd2
    } snap_op_e;

    // A frame end outranks a pending configuration refresh.
    function automatic snap_op_e pick_snap_op(input logic frame_end, input logic refresh);
        if (frame_end)
            return SNAP_COPY;
        else if (refresh)
            return SNAP_REFRESH;
        return SNAP_KEEP;
    endfunction

    // Next state of a cell. A live condition always keeps the latch set.
    function automatic cell_st_t cell_next(input cell_st_t cur, input logic cond,
                                           input logic rep_pulse);
        cell_st_t nx;
        logic     rep_any;
        rep_any = cur.reported | rep_pulse;
        if (cond) begin
            nx.latched  = 1'b1;
            nx.reported = cur.latched & rep_any;
        end else if (cur.latched && rep_any) begin
            nx.latched  = 1'b0;
            nx.reported = 1'b0;
        end else begin
            nx.latched  = cur.latched;
            nx.reported = cur.latched & rep_any;
        end
        return nx;
    endfunction

endpackage

// File: rtl/fdb_sync_edge.sv
`timescale 1ns/1ps
module fdb_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst)
            chain_q <= '1;
        else
            chain_q <= {chain_q[STAGES-1:0], async_i};
    end

    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

    // R3
    rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o)
        else $error("release edge detected two cycles running");

endmodule

// File: rtl/fdb_fault_cell.sv
`timescale 1ns/1ps
module fdb_fault_cell
    import fdb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic rep_pulse_i,
    output logic latched_o
);
    cell_st_t st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= cell_next(st_q, cond_i, rep_pulse_i);
    end

    assign latched_o = st_q.latched;

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cond_i |=> latched_o)
        else $error("live fault did not leave latch set");

    // R4
    clear_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(latched_o) |-> (!$past(cond_i) && $past(st_q.reported || rep_pulse_i)))
        else $error("latch cleared without report or with condition present");

endmodule

// File: rtl/fdb_refresh_timer.sv
`timescale 1ns/1ps
module fdb_refresh_timer #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic cancel_i,
    output logic fire_o
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (arm_i)
            cnt_q <= CW'(DLY);
        else if (cancel_i)
            cnt_q <= '0;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign fire_o = (cnt_q == CW'(1));

    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DLY))
        else $error("refresh counter out of range");

    // R8
    cancel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cancel_i && !arm_i) |=> !fire_o)
        else $error("refresh fired after cancel");

endmodule

// File: rtl/fault_dbuf_reg.sv
`timescale 1ns/1ps
module fault_dbuf_reg
    import fdb_pkg::*;
#(
    parameter int NF          = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CFG_BIT     = 2,
    parameter int RS_DLY      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic [NF-1:0] fault_in,
    input  logic          cfg_cmd,
    input  logic          rsp_load,
    input  logic          tx_done,
    output logic [NF-1:0] snap_o
);
    logic          frame_end;
    logic          refresh_fire;
    logic [NF-1:0] inner_w;
    logic [NF-1:0] rep_pulse;
    logic [NF-1:0] snap_q;
    logic [NF-1:0] sent_q;
    snap_op_e      snap_op;

    fdb_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(cs_n),
        .rise_o (frame_end)
    );

    fdb_refresh_timer #(.DLY(RS_DLY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm_i   (frame_end & cfg_cmd),
        .cancel_i(frame_end & ~cfg_cmd),
        .fire_o  (refresh_fire)
    );

    // A report counts only for bits present in the word that was loaded.
    assign rep_pulse = {NF{tx_done}} & sent_q;

    for (genvar i = 0; i < NF; i++) begin : g_cell
        fdb_fault_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .cond_i     (fault_in[i]),
            .rep_pulse_i(rep_pulse[i]),
            .latched_o  (inner_w[i])
        );
    end

    assign snap_op = pick_snap_op(frame_end, refresh_fire);

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= '0;
            sent_q <= '0;
        end else begin
            case (snap_op)
                SNAP_COPY:    snap_q <= inner_w;
                SNAP_REFRESH: snap_q[CFG_BIT] <= fault_in[CFG_BIT];
                default:      snap_q <= snap_q;
            endcase
            if (rsp_load)
                sent_q <= snap_q;
        end
    end

    assign snap_o = snap_q;

    // R3
    snap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!frame_end && !refresh_fire) |=> $stable(snap_q))
        else $error("snapshot moved outside frame end or refresh");

    // R2
    snap_copy_chk: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (snap_q == $past(inner_w)))
        else $error("snapshot differs from inner layer after frame end");

    // R7
    refresh_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (refresh_fire && !frame_end) |=> (snap_q[CFG_BIT] == $past(fault_in[CFG_BIT])))
        else $error("refreshed bit does not follow live condition");

endmodule

// File: tb/sim_fault_dbuf_reg.sv
`timescale 1ns/1ps
module sim_fault_dbuf_reg;
    localparam int NF  = 8;
    localparam int CFG = 2;
    localparam int DLY = 8;

    // [15:8] one-cycle fault pattern, [7:0] expected snapshot after the next frame
    localparam logic [15:0] VEC [5] = '{
        {8'h01, 8'h01}, {8'h10, 8'h11}, {8'h0C, 8'h1D}, {8'h00, 8'h1D}, {8'h80, 8'h9D}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1;
    logic [NF-1:0] fault_in = '0;
    logic          cfg_cmd = 1'b0;
    logic          rsp_load = 1'b0;
    logic          tx_done = 1'b0;
    logic [NF-1:0] snap_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    fault_dbuf_reg #(.NF(NF), .SYNC_STAGES(2), .CFG_BIT(CFG), .RS_DLY(DLY)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .fault_in(fault_in), .cfg_cmd(cfg_cmd),
        .rsp_load(rsp_load), .tx_done(tx_done), .snap_o(snap_o)
    );

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [NF-1:0] act, input logic [NF-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: snap_o got %h expected %h", req, act, exp);
        end
    endtask

    // low window, release, then three edges: snapshot loaded on the last
    task automatic frame(input logic cfg);
        cs_n = 1'b0;
        step(2);
        cs_n = 1'b1;
        cfg_cmd = cfg;
        step(3);
        cfg_cmd = 1'b0;
    endtask

    task automatic pulse_load();
        rsp_load = 1'b1; step(1); rsp_load = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_done = 1'b1; step(1); tx_done = 1'b0;
    endtask

    task automatic clear_all();
        frame(1'b0);
        pulse_load();
        pulse_tx();
        step(1);
        frame(1'b0);
        pulse_load();
    endtask

    initial begin
        @(negedge clk);
        step(3);
        rst = 1'b0;
        step(1);
        chk("R1 reset", snap_o, 8'h00);

        // table walk: sticky set, snapshot only at frame end
        for (int i = 0; i < 5; i++) begin
            fault_in = VEC[i][15:8];
            step(1);
            fault_in = '0;
            step(1);
            chk("R3 hold before frame", snap_o, (i == 0) ? 8'h00 : VEC[i-1][7:0]);
            frame(1'b0);
            chk("R2 snapshot after frame", snap_o, VEC[i][7:0]);
        end

        // report strobe with nothing loaded
        pulse_tx();
        step(1);
        frame(1'b0);
        chk("R5 tx_done without load", snap_o, 8'h9D);

        // full report with conditions gone
        pulse_load();
        pulse_tx();
        step(1);
        frame(1'b0);
        chk("R4 clear after report", snap_o, 8'h00);

        // report while condition still present
        fault_in = 8'h40;
        step(1);
        frame(1'b0);
        chk("R4 present fault latched", snap_o, 8'h40);
        pulse_load();
        pulse_tx();
        step(2);
        frame(1'b0);
        chk("R4 reported but present", snap_o, 8'h40);
        fault_in = '0;
        step(2);
        frame(1'b0);
        chk("R4 clears once gone", snap_o, 8'h00);
        pulse_load();

        // set and clear on the same edge
        fault_in = 8'h08;
        step(1);
        fault_in = '0;
        frame(1'b0);
        chk("R6 setup", snap_o, 8'h08);
        pulse_load();
        step(1);
        cs_n = 1'b0;
        step(2);
        cs_n = 1'b1;
        step(1);
        fault_in = 8'h08;
        tx_done = 1'b1;
        step(1);
        fault_in = '0;
        tx_done = 1'b0;
        step(1);
        chk("R6 set wins over clear", snap_o, 8'h08);
        frame(1'b0);
        chk("R6 later clear", snap_o, 8'h00);
        pulse_load();

        // configuration refresh
        fault_in = 8'h20;
        step(1);
        fault_in = '0;
        frame(1'b1);
        fault_in[CFG] = 1'b1;
        step(DLY - 1);
        chk("R7 before refresh", snap_o, 8'h20);
        step(1);
        chk("R7 refreshed bit only", snap_o, 8'h24);
        fault_in = '0;
        clear_all();
        chk("R7 cleanup", snap_o, 8'h00);

        frame(1'b0);
        fault_in[CFG] = 1'b1;
        step(DLY + 2);
        chk("R7 no refresh without cfg", snap_o, 8'h00);
        fault_in = '0;
        clear_all();

        // pending refresh cancelled by a later frame end
        cs_n = 1'b0;
        step(2);
        cs_n = 1'b1;
        cfg_cmd = 1'b1;
        fault_in = 8'h04;
        step(3);
        cfg_cmd = 1'b0;
        fault_in = '0;
        chk("R8 armed snapshot", snap_o, 8'h04);
        cs_n = 1'b0;
        step(1);
        cs_n = 1'b1;
        step(3);
        step(6);
        chk("R8 refresh cancelled", snap_o, 8'h04);
        clear_all();

        // reset with faults latched
        fault_in = 8'hFF;
        step(1);
        fault_in = '0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        frame(1'b0);
        chk("R1 reset clears inner", snap_o, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule